// File: doc/BRIEF.md
# History-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit saturating counters and a shift register of recent branch outcomes. A table entry is picked by placing the outcome history bits above a group of low program-counter bits. The lookup side takes a fetch address and answers, in the same cycle, with a taken or not-taken guess. The update side takes a resolved branch's address and real outcome under a valid strobe. It trains the entry that the lookup would have used for that branch, then moves the outcome into the history.

Each counter is a four-state machine. The states, from lowest to highest, are `CTR_STRONG_NT` (0), `CTR_WEAK_NT` (1), `CTR_WEAK_T` (2) and `CTR_STRONG_T` (3). The transitions are:

- A taken outcome steps one state up: STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, WEAK_T to STRONG_T, and STRONG_T stays put.
- A not-taken outcome steps one state down in the same way, and STRONG_NT stays put.
- With no update aimed at the entry, the state holds.

A parameter can remove the predictor. Without it, the guess is always not taken.

Top module: `bdir_predictor`

## Requirements
- R1: After reset every counter is in `CTR_WEAK_NT` (2'b01) and the history register is all zeros, so every lookup predicts not taken.
- R2: The table index is `{history[HIST_BITS-1:0], pc[PC_IDX_BITS:1]}`, with the history in the upper bits. PC bit 0 and the PC bits above `PC_IDX_BITS` do not affect the index.
- R3: `look_taken` is bit 1 of the counter at the index formed from `look_pc` and the current history. It is valid in the same cycle as `look_pc`.
- R4: A valid update with `res_taken`=1 moves the indexed counter one state up, saturating at `CTR_STRONG_T` (3).
- R5: A valid update with `res_taken`=0 moves the indexed counter one state down, saturating at `CTR_STRONG_NT` (0).
- R6: The update index is formed from `res_pc` and the history as it was before that update shifts it.
- R7: On a valid update the history shifts left by one, and `res_taken` enters at bit 0.
- R8: While `res_valid` is 0, the values on `res_pc` and `res_taken` have no effect: no counter and no history bit changes.
- R9: When a lookup and an update select the same entry in the same cycle, the lookup returns the counter value from before the update.
- R10: With `PRESENT`=0, `look_taken` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| look_pc | input | PC_W | Fetch address to predict for |
| look_taken | output | 1 | Prediction for `look_pc`: 1 = taken |
| res_valid | input | 1 | A branch has resolved this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench builds the predictor with the default 4 history bits and 4 PC bits. This gives a 256-entry table, small enough that long runs of one outcome push the history to all ones or all zeros and drive single counters into both saturation states. A second copy built with `PRESENT`=0 receives the same stimulus, so the always-not-taken behaviour is observed next to the live predictor. Addresses that differ only in bit 0 or in high bits show that those bits are ignored. Same-cycle lookup and update on one entry exercise the old-value read.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WEAK_NT;

    // Next state of one saturating counter for a resolved outcome.
    function automatic ctr_state_e ctr_step(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_RESET;
        endcase
        return nxt;
    endfunction

    // Prediction carried by a counter state.
    function automatic logic ctr_says_taken(input ctr_state_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bdp_history.sv
module bdp_history #(
    parameter int HIST_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [HIST_BITS-1:0] hist_o
);

    logic [HIST_BITS-1:0] hist_q;
    logic [HIST_BITS-1:0] hist_d;

    // Newest outcome enters at bit 0; the oldest bit falls off the top.
    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = HIST_BITS'({hist_q, bit_in});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/bdp_index.sv
module bdp_index #(
    parameter int PC_W        = 32,
    parameter int HIST_BITS   = 4,
    parameter int PC_IDX_BITS = 4,
    localparam int IDX_W      = HIST_BITS + PC_IDX_BITS
) (
    input  logic [HIST_BITS-1:0] hist,
    input  logic [PC_W-1:0]      pc,
    output logic [IDX_W-1:0]     idx
);

    // Parcels are 16-bit aligned, so PC bit 0 carries no information.
    assign idx = {hist, pc[PC_IDX_BITS:1]};

endmodule

// File: rtl/bdp_counter_table.sv
module bdp_counter_table
    import bdp_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    logic [DEPTH-1:0] taken_vec;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        ctr_state_e st_q;
        ctr_state_e st_d;

        always_comb begin
            st_d = st_q;
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                st_d = ctr_step(st_q, wr_taken);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= CTR_RESET;
            end else begin
                st_q <= st_d;
            end
        end

        assign taken_vec[e] = ctr_says_taken(st_q);
    end

    // Read from the registered state: a same-cycle write is not visible yet.
    assign rd_taken = taken_vec[rd_idx];

endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor #(
    parameter bit PRESENT     = 1'b1,
    parameter int PC_W        = 32,
    parameter int HIST_BITS   = 4,
    parameter int PC_IDX_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] look_pc,
    output logic            look_taken,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken
);

    localparam int IDX_W = HIST_BITS + PC_IDX_BITS;

    logic [HIST_BITS-1:0] hist_q;

    if (PRESENT) begin : g_on
        logic [IDX_W-1:0] look_idx;
        logic [IDX_W-1:0] res_idx;

        bdp_history #(.HIST_BITS(HIST_BITS)) u_hist (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (res_valid),
            .bit_in   (res_taken),
            .hist_o   (hist_q)
        );

        bdp_index #(.PC_W(PC_W), .HIST_BITS(HIST_BITS), .PC_IDX_BITS(PC_IDX_BITS)) u_look_idx (
            .hist (hist_q),
            .pc   (look_pc),
            .idx  (look_idx)
        );

        bdp_index #(.PC_W(PC_W), .HIST_BITS(HIST_BITS), .PC_IDX_BITS(PC_IDX_BITS)) u_res_idx (
            .hist (hist_q),
            .pc   (res_pc),
            .idx  (res_idx)
        );

        bdp_counter_table #(.IDX_W(IDX_W)) u_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (look_idx),
            .rd_taken (look_taken),
            .wr_en    (res_valid),
            .wr_idx   (res_idx),
            .wr_taken (res_taken)
        );
    end else begin : g_off
        assign hist_q     = '0;
        assign look_taken = 1'b0;
    end

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter bit PRESENT     = 1'b1,
    parameter int PC_W        = 32,
    parameter int HIST_BITS   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PC_W-1:0]      look_pc,
    input logic                 look_taken,
    input logic                 res_valid,
    input logic                 res_taken,
    input logic [HIST_BITS-1:0] hist_q
);

    if (PRESENT) begin : g_live
        // R1: history leaves reset cleared
        assert_hist_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (hist_q == '0));

        // R7: outcome enters at bit 0 on a valid update
        assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |=> (hist_q == HIST_BITS'({$past(hist_q), $past(res_taken)})));

        // R8: history holds without a valid update
        assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !res_valid |=> $stable(hist_q));

        // R8: same lookup address and no update leave the prediction unchanged
        assert_look_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !res_valid |=> ($stable(look_pc) -> $stable(look_taken)));
    end else begin : g_absent
        // R10: removed predictor never predicts taken
        always @(posedge clk) begin
            if (rst_n) begin
                assert_absent_R10: assert (look_taken == 1'b0);
            end
        end
    end

endmodule

bind bdir_predictor bdp_checker #(
    .PRESENT   (PRESENT),
    .PC_W      (PC_W),
    .HIST_BITS (HIST_BITS)
) u_bdp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_pc    (look_pc),
    .look_taken (look_taken),
    .res_valid  (res_valid),
    .res_taken  (res_taken),
    .hist_q     (hist_q)
);

// File: tb/test_bdir_predictor.sv
`timescale 1ns/1ps
module test_bdir_predictor;

    localparam int PC_W = 32;
    localparam int HB   = 4;
    localparam int PB   = 4;
    localparam int IW   = HB + PB;
    localparam int DEP  = 1 << IW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] look_pc = '0;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0;
    logic            look_taken;
    logic            look_taken_off;

    always #2.5 clk = ~clk;

    bdir_predictor #(.PRESENT(1'b1), .PC_W(PC_W), .HIST_BITS(HB), .PC_IDX_BITS(PB)) i_bdir_predictor (
        .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .look_taken(look_taken),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
    );

    bdir_predictor #(.PRESENT(1'b0), .PC_W(PC_W), .HIST_BITS(HB), .PC_IDX_BITS(PB)) i_bdir_predictor_absent (
        .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .look_taken(look_taken_off),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
    );

    typedef struct {
        bit    exp;
        string req;
    } exp_t;

    exp_t     sb_q[$];
    int       checks = 0;
    int       fails  = 0;
    bit       done   = 1'b0;
    bit [1:0] m_tab [DEP];
    bit [HB-1:0] m_hist;

    function automatic int m_idx(input logic [PC_W-1:0] pc);
        return int'({m_hist, pc[PB:1]});
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEP; i++) m_tab[i] = 2'd1;
        m_hist = '0;
    endtask

    // Driver: apply one cycle of stimulus, push the expected prediction, then advance the model.
    task automatic step(input logic [PC_W-1:0] lpc, input bit uv,
                        input logic [PC_W-1:0] upc, input bit ut, input string req);
        exp_t e;
        int   k;
        @(posedge clk);
        #1;
        look_pc   = lpc;
        res_valid = uv;
        res_pc    = upc;
        res_taken = ut;
        e.exp = m_tab[m_idx(lpc)][1];
        e.req = req;
        sb_q.push_back(e);
        if (uv) begin
            k = m_idx(upc);
            if (ut && m_tab[k] != 2'd3) m_tab[k] = m_tab[k] + 2'd1;
            if (!ut && m_tab[k] != 2'd0) m_tab[k] = m_tab[k] - 2'd1;
            m_hist = HB'({m_hist, ut});
        end
    endtask

    // Monitor: compare outputs mid-cycle against the scoreboard.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (look_taken !== e.exp) begin
                fails++;
                $display("FAIL %s: look_taken actual=%0b expected=%0b pc=%h", e.req, look_taken, e.exp, look_pc);
            end
            checks++;
            if (look_taken_off !== 1'b0) begin
                fails++;
                $display("FAIL R10: absent look_taken actual=%0b expected=0", look_taken_off);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: fresh state predicts not taken everywhere
        step(32'h0000_0000, 0, 0, 0, "R1");
        step(32'h0000_001E, 0, 0, 0, "R1");
        step(32'hFFFF_FFFE, 0, 0, 0, "R1");
        step(32'h1234_5678, 0, 0, 0, "R1");

        // R4: repeated taken outcomes saturate the all-ones-history entry
        for (int i = 0; i < 9; i++) step(32'h0000_0040 + 32'h6, 1, 32'h0000_0046, 1, "R4");
        step(32'h0000_0046, 0, 0, 0, "R4");

        // R2: bit 0 and high bits do not change the index
        step(32'h0000_0047, 0, 0, 0, "R2");
        step(32'hABCD_0066, 0, 0, 0, "R2");
        step(32'h0000_0044, 0, 0, 0, "R2");

        // R9: lookup and update on the same entry in one cycle see the old value
        step(32'h0000_0046, 1, 32'h0000_0046, 0, "R9");
        step(32'h0000_0046, 1, 32'h0000_0046, 0, "R9");

        // R5: not-taken outcomes saturate low
        for (int i = 0; i < 9; i++) step(32'h0000_0046, 1, 32'h0000_0046, 0, "R5");
        step(32'h0000_0046, 0, 0, 0, "R5");

        // R8: strobe low, other update inputs wiggle
        for (int i = 0; i < 8; i++) step(32'h0000_0046 + 32'(2 * i), 0, 32'(2 * i), 1, "R8");

        // R6 / R7: alternate outcomes so history and pre-shift indexing matter
        for (int i = 0; i < 12; i++) step(32'h0000_0010, 1, 32'h0000_0010, i[0], "R6");
        for (int i = 0; i < 16; i++) step(32'(2 * i), 0, 0, 0, "R7");

        // R3: pseudo-random mix
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step({16'h0, lf} ^ 32'h0000_0500, lf[3] | lf[7], {lf[7:0], lf[15:8]} & 32'h0000_003E, lf[11] ^ lf[0], "R3");
        end

        step(32'h0000_0000, 0, 0, 0, "R3");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule